// File: doc/BRIEF.md
# Multicycle Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline whose execute phase has functional units of unequal length. These are a one-cycle integer unit, a pipelined floating-point adder with three extra execute cycles, and a pipelined floating-point multiplier with six extra cycles. There is also an unpipelined floating-point divider that holds its execute stage for twenty-four cycles. For every decoded instruction the block receives the unit it targets, an optional destination and up to two source operands. In the same cycle it answers whether that instruction may leave decode or must wait.

The block keeps three kinds of tracking state. A per-register countdown in each register file gives the cycles left until a pending result is written back. A one-bit-per-future-cycle map records when the single write-back port is already claimed. A busy counter covers the divider. Operands are read in decode, so write-after-read ordering never needs a check. A stalled instruction stays in decode and leaves all tracking state untouched. Data paths and forwarding multiplexers live elsewhere.

Top module: `fp_issue_hazard`

## Requirements
- R1: After a synchronous active-low reset nothing is pending. Any instruction presented with the valid flag set issues at once.
- R2: `stall` is high exactly when a valid instruction has at least one hazard, and `issue` is high exactly when a valid instruction has none. With the valid flag low both are low. Unit codes are 0 integer, 1 FP add, 2 FP multiply and 3 FP divide.
- R3: A divide that issues in cycle t blocks every other divide in cycles t+1 to t+23. The next divide may issue in cycle t+24.
- R4: Independent adds may issue in consecutive cycles, so four are in flight at once. The same holds for multiplies, with seven in flight at once.
- R5: An instruction that reads a register written by an in-flight instruction with E extra execute cycles, issued in cycle t, stalls through cycle t+E and issues in t+E+1. Integer-to-integer use never stalls. A source whose use flag is low is never checked.
- R6: An instruction whose write-back would occur at or before the write-back of a pending result to the same register stalls. A divide to f1 in cycle t holds a later add to f1 until cycle t+22.
- R7: Write-back happens 3 cycles after issue plus the unit's extra cycles. An instruction whose write-back cycle is already claimed stalls. An add in cycle t blocks an integer write in cycle t+3, and a multiply in cycle t blocks an add in cycle t+3.
- R8: Writing a register that an earlier in-flight instruction reads causes no stall.
- R9: The integer and FP register files are tracked separately. A pending FP register never stalls an integer access to the same index.
- R10: An instruction with no destination claims no write-back slot. It is checked for neither port conflicts nor write-after-write.
- R11: A stalled instruction changes no tracking state. A register it names as destination is not pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_valid | input | 1 | An instruction is present in decode |
| id_unit | input | 2 | Target unit: 0 int, 1 add, 2 mul, 3 div |
| id_has_dst | input | 1 | Instruction writes a register |
| id_dst_fp | input | 1 | Destination is in the FP file |
| id_dst | input | REG_W | Destination register index |
| id_a_use | input | 1 | First source is read |
| id_a_fp | input | 1 | First source is in the FP file |
| id_a | input | REG_W | First source index |
| id_b_use | input | 1 | Second source is read |
| id_b_fp | input | 1 | Second source is in the FP file |
| id_b | input | REG_W | Second source index |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode |

## Verification
Several hazards can apply to one instruction in the same cycle. The case that matters most is a write-back port collision landing on the same cycle as a write-after-write on that register. A multiply to f3 followed three cycles later by an add to f3 provokes both, and the stall is judged against the later of the two release cycles. Each scenario starts from reset and presents instructions on the falling edge. The bench compares `issue` and `stall` before the next rising edge against cycle numbers worked out from the issue-to-write-back offsets. That method also separates the divider's occupancy window from a write-after-write hold on the same register.

// File: rtl/fp_hz_pkg.sv
// Shared unit codes for the issue hazard checker.
// Assumes a 2-bit unit field decoded upstream.
package fp_hz_pkg;
    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_ADD = 2'd1,
        U_MUL = 2'd2,
        U_DIV = 2'd3
    } unit_e;
endpackage

// File: rtl/fp_hz_regcnt.sv
// Per-register countdown of cycles until a pending write-back.
// Zero means nothing pending. A write loads the full distance;
// otherwise each nonzero entry counts down by one per cycle.
// Assumes the writer never loads a value above MAX_V.
module fp_hz_regcnt #(
    parameter int REG_W = 5,
    parameter int CNT_W = 5,
    parameter int MAX_V = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    input  logic [REG_W-1:0] rd_d,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic [CNT_W-1:0] cnt_d
);
    localparam int NREG = 1 << REG_W;

    logic [CNT_W-1:0] left_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_idx == REG_W'(i));

        // Load on issue, otherwise count toward zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                left_q[i] <= '0;
            else if (hit)
                left_q[i] <= wr_val;
            else if (left_q[i] != '0)
                left_q[i] <= left_q[i] - 1'b1;
        end

        // R6: an untouched pending entry moves one step closer each cycle
        a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
            (left_q[i] != '0 && !hit) |=> (left_q[i] == $past(left_q[i]) - 1'b1));

        // R5: no entry ever claims a completion beyond the longest unit
        a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            left_q[i] <= CNT_W'(MAX_V));
    end

    // Read ports for both sources and the destination.
    assign cnt_a = left_q[rd_a];
    assign cnt_b = left_q[rd_b];
    assign cnt_d = left_q[rd_d];
endmodule

// File: rtl/fp_hz_wbslots.sv
// Write-back port reservation map: slot k set means the port is
// taken k cycles from now. The map shifts down once per cycle.
// Assumes offsets of 2 or more; slot 0 is not kept.
module fp_hz_wbslots #(
    parameter int MAX_OFF = 27,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] q_off,
    output logic             busy,
    input  logic             set_en
);
    logic [MAX_OFF:1] slot_q;

    for (genvar k = 1; k < MAX_OFF; k++) begin : g_slot
        // Shift toward now and book the issuing instruction's slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[k] <= 1'b0;
            else
                slot_q[k] <= slot_q[k+1] | (set_en && q_off == CNT_W'(k + 1));
        end
    end

    // The farthest slot only ever receives zeros from beyond the horizon.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q[MAX_OFF] <= 1'b0;
        else
            slot_q[MAX_OFF] <= 1'b0;
    end

    // Look up the queried future cycle.
    always_comb begin
        busy = 1'b0;
        for (int k = 1; k <= MAX_OFF; k++)
            if (q_off == CNT_W'(k)) busy = slot_q[k];
    end

    // R7: the port is never booked twice for the same cycle
    a_r7_no_double_book: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !busy);
endmodule

// File: rtl/fp_hz_divbusy.sv
// Occupancy of the unpipelined divider. A start loads the
// remaining busy cycles; busy stays high until the unit frees.
// Assumes start is never raised while busy.
module fp_hz_divbusy #(
    parameter int DIV_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int LW = $clog2(DIV_CYC + 1);

    logic [LW-1:0] left_q;

    // Load on start, count down while occupied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (start)
            left_q <= LW'(DIV_CYC - 1);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    // R3: only one divide may occupy the unit
    a_r3_single_divide: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R3: occupancy drains one cycle at a time
    a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/fp_issue_hazard.sv
// Decode-stage issue/stall decision for units of unequal latency.
// Combines read-after-write, write-after-write, write-back port and
// divider occupancy hazards. Operands are read in decode, so
// write-after-read is not checked. Assumes the instruction is held
// in decode while stall is high.
module fp_issue_hazard
    import fp_hz_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int BASE_WB   = 3,
    parameter int EXTRA_ADD = 3,
    parameter int EXTRA_MUL = 6,
    parameter int EXTRA_DIV = 24,
    parameter int FWD_SLACK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [1:0]       id_unit,
    input  logic             id_has_dst,
    input  logic             id_dst_fp,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_a_use,
    input  logic             id_a_fp,
    input  logic [REG_W-1:0] id_a,
    input  logic             id_b_use,
    input  logic             id_b_fp,
    input  logic [REG_W-1:0] id_b,
    output logic             issue,
    output logic             stall
);
    localparam int OFF_INT = BASE_WB;
    localparam int OFF_ADD = BASE_WB + EXTRA_ADD;
    localparam int OFF_MUL = BASE_WB + EXTRA_MUL;
    localparam int OFF_DIV = BASE_WB + EXTRA_DIV;
    localparam int MAX_A   = (OFF_ADD > OFF_MUL) ? OFF_ADD : OFF_MUL;
    localparam int MAX_OFF = (MAX_A > OFF_DIV) ? MAX_A : OFF_DIV;
    localparam int CNT_W   = $clog2(MAX_OFF + 1);
    localparam logic [CNT_W-1:0] FWD_C = CNT_W'(FWD_SLACK);

    logic [CNT_W-1:0] wb_off;
    logic [CNT_W-1:0] cnt_a, cnt_b, cnt_d;
    logic [CNT_W-1:0] i_a, i_b, i_d, f_a, f_b, f_d;
    logic             slot_busy, div_busy, is_div;
    logic             raw_hz, waw_hz, port_hz, div_hz, any_hz;
    logic             wr_go;

    // Issue-to-write-back distance for the presented unit.
    always_comb begin
        unique case (unit_e'(id_unit))
            U_INT:   wb_off = CNT_W'(OFF_INT);
            U_ADD:   wb_off = CNT_W'(OFF_ADD);
            U_MUL:   wb_off = CNT_W'(OFF_MUL);
            default: wb_off = CNT_W'(OFF_DIV);
        endcase
    end

    assign is_div = (unit_e'(id_unit) == U_DIV);
    assign wr_go  = issue && id_has_dst;

    fp_hz_regcnt #(.REG_W(REG_W), .CNT_W(CNT_W), .MAX_V(MAX_OFF - 1)) u_int_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go && !id_dst_fp), .wr_idx(id_dst), .wr_val(wb_off - 1'b1),
        .rd_a(id_a), .rd_b(id_b), .rd_d(id_dst),
        .cnt_a(i_a), .cnt_b(i_b), .cnt_d(i_d)
    );

    fp_hz_regcnt #(.REG_W(REG_W), .CNT_W(CNT_W), .MAX_V(MAX_OFF - 1)) u_fp_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go && id_dst_fp), .wr_idx(id_dst), .wr_val(wb_off - 1'b1),
        .rd_a(id_a), .rd_b(id_b), .rd_d(id_dst),
        .cnt_a(f_a), .cnt_b(f_b), .cnt_d(f_d)
    );

    fp_hz_wbslots #(.MAX_OFF(MAX_OFF), .CNT_W(CNT_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .q_off(wb_off), .busy(slot_busy), .set_en(wr_go)
    );

    fp_hz_divbusy #(.DIV_CYC(EXTRA_DIV)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(issue && is_div), .busy(div_busy)
    );

    // Pick each operand's countdown from its own register file.
    assign cnt_a = id_a_fp   ? f_a : i_a;
    assign cnt_b = id_b_fp   ? f_b : i_b;
    assign cnt_d = id_dst_fp ? f_d : i_d;

    // Classify hazards and form the decision.
    always_comb begin
        raw_hz  = (id_a_use && cnt_a > FWD_C) || (id_b_use && cnt_b > FWD_C);
        waw_hz  = id_has_dst && (cnt_d >= wb_off);
        port_hz = id_has_dst && slot_busy;
        div_hz  = is_div && div_busy;
        any_hz  = raw_hz || waw_hz || port_hz || div_hz;
        issue   = id_valid && !any_hz;
        stall   = id_valid && any_hz;
    end

    // R3: two divides never issue in adjacent cycles
    a_r3_no_adjacent_div: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_div) |=> !(issue && is_div));

    // R6: an issuing write always completes after any pending one
    a_r6_waw_order: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && id_has_dst) |-> (cnt_d < wb_off));
endmodule

// File: tb/tb_fp_issue_hazard.sv
module tb_fp_issue_hazard;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] UI = 2'd0, UA = 2'd1, UM = 2'd2, UD = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid, id_has_dst, id_dst_fp;
    logic [1:0] id_unit;
    logic [4:0] id_dst, id_a, id_b;
    logic       id_a_use, id_a_fp, id_b_use, id_b_fp;
    logic       issue, stall;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_issue_hazard dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_unit(id_unit),
        .id_has_dst(id_has_dst), .id_dst_fp(id_dst_fp), .id_dst(id_dst),
        .id_a_use(id_a_use), .id_a_fp(id_a_fp), .id_a(id_a),
        .id_b_use(id_b_use), .id_b_fp(id_b_fp), .id_b(id_b),
        .issue(issue), .stall(stall)
    );

    // Present one instruction for one cycle, on the falling edge.
    task automatic pres(input logic v, input logic [1:0] u, input logic hd,
                        input logic dfp, input int d,
                        input logic au, input logic afp, input int a,
                        input logic bu, input logic bfp, input int b);
        @(negedge clk);
        id_valid = v; id_unit = u; id_has_dst = hd; id_dst_fp = dfp;
        id_dst = 5'(d); id_a_use = au; id_a_fp = afp; id_a = 5'(a);
        id_b_use = bu; id_b_fp = bfp; id_b = 5'(b);
        #1;
    endtask

    task automatic idle();
        pres(1'b0, UI, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic chk(input logic ei, input logic es, input string req);
        checks++;
        if (issue !== ei || stall !== es) begin
            errors++;
            $display("FAIL %s: issue/stall=%b/%b expected %b/%b at %0t",
                     req, issue, stall, ei, es, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: fresh state lets anything issue
    task automatic t_reset();
        do_reset();
        idle();                                           chk(0, 0, "R1 idle");
        pres(1, UD, 1, 1, 4, 1, 1, 5, 1, 1, 6);           chk(1, 0, "R1 div");
    endtask

    // R3 with R2: divider occupancy window and idle behaviour
    task automatic t_div();
        do_reset();
        pres(1, UD, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R3 first");
        for (int i = 1; i <= 23; i++) begin
            if (i == 5) begin
                pres(0, UD, 1, 1, 2, 0, 1, 0, 0, 1, 0);   chk(0, 0, "R2 idle");
            end else begin
                pres(1, UD, 1, 1, 2, 0, 1, 0, 0, 1, 0);   chk(0, 1, "R3 busy");
            end
        end
        pres(1, UD, 1, 1, 2, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R3 free");
    endtask

    // R4: pipelined units accept one per cycle
    task automatic t_pipe();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            pres(1, UA, 1, 1, 1 + i, 0, 1, 0, 0, 1, 0);   chk(1, 0, "R4 add");
        end
        for (int i = 0; i < 7; i++) begin
            pres(1, UM, 1, 1, 10 + i, 0, 1, 0, 0, 1, 0);  chk(1, 0, "R4 mul");
        end
    endtask

    // R5: read-after-write release cycles
    task automatic t_raw();
        do_reset();
        pres(1, UA, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R5 add");
        for (int i = 1; i <= 3; i++) begin
            pres(1, UA, 1, 1, 2, 1, 1, 1, 0, 1, 0);       chk(0, 1, "R5 wait add");
        end
        pres(1, UA, 1, 1, 2, 1, 1, 1, 0, 1, 0);           chk(1, 0, "R5 go add");
        do_reset();
        pres(1, UM, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R5 mul");
        for (int i = 1; i <= 6; i++) begin
            pres(1, UA, 1, 1, 2, 0, 1, 0, 1, 1, 1);       chk(0, 1, "R5 wait mul");
        end
        pres(1, UA, 1, 1, 2, 0, 1, 0, 1, 1, 1);           chk(1, 0, "R5 go mul");
        do_reset();
        pres(1, UI, 1, 0, 1, 0, 0, 0, 0, 0, 0);           chk(1, 0, "R5 int");
        pres(1, UI, 1, 0, 2, 1, 0, 1, 0, 0, 0);           chk(1, 0, "R5 int use");
        do_reset();
        pres(1, UM, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R5 mul2");
        pres(1, UA, 1, 1, 2, 0, 1, 1, 0, 1, 1);           chk(1, 0, "R5 unused src");
    endtask

    // R6: write-after-write ordering
    task automatic t_waw();
        do_reset();
        pres(1, UD, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R6 div");
        for (int i = 1; i <= 21; i++) begin
            pres(1, UA, 1, 1, 1, 0, 1, 0, 0, 1, 0);       chk(0, 1, "R6 hold");
        end
        pres(1, UA, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R6 release");
        do_reset();
        pres(1, UM, 1, 1, 3, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R6 mul");
        idle();
        idle();
        pres(1, UA, 1, 1, 3, 0, 1, 0, 0, 1, 0);           chk(0, 1, "R6 same cycle");
        pres(1, UA, 1, 1, 3, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R6 after");
    endtask

    // R7: single write-back port
    task automatic t_port();
        do_reset();
        pres(1, UA, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R7 add");
        pres(1, UI, 1, 0, 1, 0, 0, 0, 0, 0, 0);           chk(1, 0, "R7 int1");
        pres(1, UI, 1, 0, 2, 0, 0, 0, 0, 0, 0);           chk(1, 0, "R7 int2");
        pres(1, UI, 1, 0, 3, 0, 0, 0, 0, 0, 0);           chk(0, 1, "R7 clash");
        pres(1, UI, 1, 0, 3, 0, 0, 0, 0, 0, 0);           chk(1, 0, "R7 next");
        do_reset();
        pres(1, UM, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R7 mul");
        idle();
        idle();
        pres(1, UA, 1, 1, 2, 0, 1, 0, 0, 1, 0);           chk(0, 1, "R7 add clash");
        pres(1, UA, 1, 1, 2, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R7 add next");
    endtask

    // R8, R9, R10, R11: cases where nothing must block
    task automatic t_misc();
        do_reset();
        pres(1, UM, 1, 1, 3, 1, 1, 1, 1, 1, 2);           chk(1, 0, "R8 mul");
        pres(1, UA, 1, 1, 1, 1, 1, 4, 1, 1, 5);           chk(1, 0, "R8 war");
        do_reset();
        pres(1, UM, 1, 1, 5, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R9 mul");
        pres(1, UI, 1, 0, 7, 1, 0, 5, 1, 0, 5);           chk(1, 0, "R9 int file");
        pres(1, UA, 1, 1, 6, 1, 1, 5, 0, 1, 0);           chk(0, 1, "R9 fp file");
        do_reset();
        pres(1, UA, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R10 add");
        idle();
        idle();
        pres(1, UI, 0, 1, 1, 0, 0, 0, 0, 0, 0);           chk(1, 0, "R10 no dst");
        do_reset();
        pres(1, UD, 1, 1, 1, 0, 1, 0, 0, 1, 0);           chk(1, 0, "R11 div");
        for (int i = 1; i <= 5; i++) begin
            pres(1, UD, 1, 1, 9, 0, 1, 0, 0, 1, 0);       chk(0, 1, "R11 held");
        end
        pres(1, UA, 1, 1, 10, 1, 1, 9, 0, 1, 0);          chk(1, 0, "R11 untouched");
    endtask

    initial begin
        rst_n = 1'b0;
        id_valid = 1'b0; id_unit = UI; id_has_dst = 1'b0; id_dst_fp = 1'b0;
        id_dst = '0; id_a_use = 1'b0; id_a_fp = 1'b0; id_a = '0;
        id_b_use = 1'b0; id_b_fp = 1'b0; id_b = '0;
        t_reset();
        t_div();
        t_pipe();
        t_raw();
        t_waw();
        t_port();
        t_misc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule